// File: doc/BRIEF.md
# SPI Command Phase Sequencer

This block follows one SPI transaction at a time, starting from the received opcode. It looks the opcode up in a table of sixteen programmable command descriptors. Each descriptor gives the shape of the command: whether an address follows and how wide it is, whether dummy cycles follow and how many, which IO lanes carry the payload, and which way the payload moves. When a descriptor matches, the sequencer steps through the address, dummy and payload phases. It counts bit strobes supplied by the SPI clock-domain front end.

The outputs are the current phase, the index of the matched slot, an address-substitution flag and a per-lane output-enable mask. A data path uses these to decide what to capture or drive on each lane. When no slot matches the opcode, the rest of the transaction is ignored. Raising chip select always returns the block to idle, whatever else happens in the same cycle.

Top module: `spi_cmd_sequencer`

## Requirements
- R1: After reset, and whenever chip select is high, `phase_o` reads 0 (idle), and `slot_hit_o`, `addr_swap_o` and `lane_oe_o` read 0. Phase codes are: 0 idle, 1 opcode, 2 address, 3 dummy, 4 payload, 5 ignore.
- R2: Each descriptor is 20 bits wide and slot k occupies bits [20k+19:20k] of `desc_table_i`. Its fields are: opcode [7:0], address present [8], address substitution [9], wide-address eligible [10], dummy count minus one [13:11], dummy enable [14], payload lane mask [18:15], payload direction [19]. When several slots hold the received opcode, the lowest-numbered slot is matched. Its index appears on `slot_o`, with `slot_hit_o` high, from the cycle after the opcode is accepted until chip select rises.
- R3: In idle with chip select low, the phase becomes opcode one cycle later. An `opcode_valid_i` pulse in the opcode phase moves the block, one cycle later, to the first phase the matched descriptor calls for: address, else dummy, else payload.
- R4: The address phase lasts 32 bit strobes when `addr_wide_i` is high at opcode acceptance and the descriptor is wide-address eligible. In every other case it lasts 24 strobes.
- R5: The dummy phase occurs only when dummy enable is set. It follows the address phase, when there is one, and lasts (dummy count minus one) + 1 strobes, so from 1 to 8.
- R6: The payload phase lasts until chip select rises. `lane_oe_o` equals the payload lane mask during the payload phase when the direction bit is 1 (device drives the host), and is 0 at all other times. Lane 1 alone (mask 4'b0010) is the single-IO read lane.
- R7: An opcode that no slot holds moves the block to the ignore phase. The block stays there, with all enables low and `slot_hit_o` low, whatever strobes arrive, until chip select rises.
- R8: Chip select high forces idle on the next cycle. It takes priority over a bit strobe that would end a phase and over an opcode pulse in the same cycle.
- R9: `addr_swap_o` is high during the address phase of a command whose substitution bit is set, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Chip select, active low |
| bit_stb_i | input | 1 | One pulse per SPI bit time |
| opcode_valid_i | input | 1 | Pulse: `opcode_i` holds a complete opcode |
| opcode_i | input | 8 | Received opcode |
| addr_wide_i | input | 1 | Global 4-byte address mode |
| desc_table_i | input | 320 | Sixteen packed 20-bit descriptors |
| phase_o | output | 3 | Current phase code |
| slot_o | output | 4 | Matched slot index |
| slot_hit_o | output | 1 | A slot matched the current opcode |
| addr_swap_o | output | 1 | Address substitution requested |
| lane_oe_o | output | 4 | Per-lane output enable |

## Verification
The function most likely to collide with a phase step is the chip-select release. It can arrive in the same cycle as the final address strobe or as an opcode pulse. The bench provokes both cases by driving `cs_n_i` high together with the last counted strobe, and separately together with `opcode_valid_i`. In each case it judges that the next cycle shows idle with every enable low, and that a following transaction starts normally from the opcode phase.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

  localparam int OPC_W   = 8;
  localparam int LANES   = 4;
  localparam int DUMMY_W = 3;

  // Packed from MSB down: opcode lands in bits [7:0].
  typedef struct packed {
    logic               pay_dir;
    logic [LANES-1:0]   pay_lanes;
    logic               dummy_en;
    logic [DUMMY_W-1:0] dummy_m1;
    logic               wide_ok;
    logic               swap;
    logic               addr_en;
    logic [OPC_W-1:0]   opcode;
  } cmd_desc_t;

  localparam int DESC_W = $bits(cmd_desc_t);

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_OPCODE  = 3'd1,
    PH_ADDR    = 3'd2,
    PH_DUMMY   = 3'd3,
    PH_PAYLOAD = 3'd4,
    PH_IGNORE  = 3'd5
  } seq_phase_e;

endpackage

// File: rtl/spi_seq_slot_match.sv
module spi_seq_slot_match
  import spi_seq_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int IDX_W     = $clog2(NUM_SLOTS)
) (
  input  logic [NUM_SLOTS*DESC_W-1:0] table_i,
  input  logic [OPC_W-1:0]            opcode_i,
  output logic                        hit_o,
  output logic [IDX_W-1:0]            idx_o,
  output cmd_desc_t                   desc_o
);

  logic [NUM_SLOTS-1:0] hits;
  cmd_desc_t            slots [NUM_SLOTS];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    assign slots[g] = cmd_desc_t'(table_i[g*DESC_W +: DESC_W]);
    assign hits[g]  = (slots[g].opcode == opcode_i);
  end

  // Lowest index wins: scan downward so the last write is the lowest hit.
  always_comb begin
    hit_o  = 1'b0;
    idx_o  = '0;
    desc_o = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (hits[i]) begin
        hit_o  = 1'b1;
        idx_o  = IDX_W'(i);
        desc_o = slots[i];
      end
    end
  end

endmodule

// File: rtl/spi_seq_bit_counter.sv
module spi_seq_bit_counter #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i) begin
      cnt_d = load_val_i;
    end else if (dec_i && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i || dec_i) begin
      cnt_q <= cnt_d;
    end
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/spi_seq_lane_drive.sv
module spi_seq_lane_drive
  import spi_seq_pkg::*;
(
  input  seq_phase_e       phase_i,
  input  cmd_desc_t        desc_i,
  output logic [LANES-1:0] lane_oe_o,
  output logic             addr_swap_o
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_oe_o[l] = (phase_i == PH_PAYLOAD) && desc_i.pay_dir && desc_i.pay_lanes[l];
  end

  assign addr_swap_o = (phase_i == PH_ADDR) && desc_i.swap;

endmodule

// File: rtl/spi_cmd_sequencer.sv
module spi_cmd_sequencer
  import spi_seq_pkg::*;
#(
  parameter int NUM_SLOTS        = 16,
  parameter int ADDR_NARROW_BITS = 24,
  parameter int ADDR_WIDE_BITS   = 32
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 cs_n_i,
  input  logic                                 bit_stb_i,
  input  logic                                 opcode_valid_i,
  input  logic [7:0]                           opcode_i,
  input  logic                                 addr_wide_i,
  input  logic [NUM_SLOTS*20-1:0]              desc_table_i,
  output logic [2:0]                           phase_o,
  output logic [$clog2(NUM_SLOTS)-1:0]         slot_o,
  output logic                                 slot_hit_o,
  output logic                                 addr_swap_o,
  output logic [3:0]                           lane_oe_o
);

  localparam int IDX_W = $clog2(NUM_SLOTS);
  localparam int CNT_W = $clog2(ADDR_WIDE_BITS);
  localparam logic [CNT_W-1:0] NARROW_LAST = CNT_W'(ADDR_NARROW_BITS - 1);
  localparam logic [CNT_W-1:0] WIDE_LAST   = CNT_W'(ADDR_WIDE_BITS - 1);

  seq_phase_e        phase_q, phase_d;
  cmd_desc_t         desc_q, sel_desc;
  logic [IDX_W-1:0]  slot_q, sel_idx;
  logic              hit_q, sel_hit;
  logic              capture;
  logic              cnt_load, cnt_dec, cnt_zero;
  logic [CNT_W-1:0]  cnt_val;

  spi_seq_slot_match #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) i_match (
    .table_i  (desc_table_i),
    .opcode_i (opcode_i),
    .hit_o    (sel_hit),
    .idx_o    (sel_idx),
    .desc_o   (sel_desc)
  );

  spi_seq_bit_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (cnt_load),
    .load_val_i (cnt_val),
    .dec_i      (cnt_dec),
    .zero_o     (cnt_zero)
  );

  // Next-state logic
  always_comb begin
    phase_d  = phase_q;
    capture  = 1'b0;
    cnt_load = 1'b0;
    cnt_val  = '0;
    if (cs_n_i) begin
      phase_d = PH_IDLE;
    end else begin
      unique case (phase_q)
        PH_IDLE:   phase_d = PH_OPCODE;
        PH_OPCODE: begin
          if (opcode_valid_i) begin
            capture = 1'b1;
            if (!sel_hit) begin
              phase_d = PH_IGNORE;
            end else if (sel_desc.addr_en) begin
              phase_d  = PH_ADDR;
              cnt_load = 1'b1;
              cnt_val  = (addr_wide_i && sel_desc.wide_ok) ? WIDE_LAST : NARROW_LAST;
            end else if (sel_desc.dummy_en) begin
              phase_d  = PH_DUMMY;
              cnt_load = 1'b1;
              cnt_val  = CNT_W'(sel_desc.dummy_m1);
            end else begin
              phase_d = PH_PAYLOAD;
            end
          end
        end
        PH_ADDR: begin
          if (bit_stb_i && cnt_zero) begin
            if (desc_q.dummy_en) begin
              phase_d  = PH_DUMMY;
              cnt_load = 1'b1;
              cnt_val  = CNT_W'(desc_q.dummy_m1);
            end else begin
              phase_d = PH_PAYLOAD;
            end
          end
        end
        PH_DUMMY: begin
          if (bit_stb_i && cnt_zero) phase_d = PH_PAYLOAD;
        end
        PH_PAYLOAD: phase_d = PH_PAYLOAD;
        PH_IGNORE:  phase_d = PH_IGNORE;
        default:    phase_d = PH_IDLE;
      endcase
    end
  end

  assign cnt_dec = bit_stb_i && !cs_n_i && ((phase_q == PH_ADDR) || (phase_q == PH_DUMMY));

  // State registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
    end else begin
      phase_q <= phase_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      desc_q <= '0;
      slot_q <= '0;
    end else if (capture) begin
      desc_q <= sel_desc;
      slot_q <= sel_idx;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q <= 1'b0;
    end else if (cs_n_i || capture) begin
      hit_q <= !cs_n_i && sel_hit;
    end
  end

  spi_seq_lane_drive i_lanes (
    .phase_i     (phase_q),
    .desc_i      (desc_q),
    .lane_oe_o   (lane_oe_o),
    .addr_swap_o (addr_swap_o)
  );

  assign phase_o    = phase_q;
  assign slot_o     = slot_q;
  assign slot_hit_o = hit_q;

endmodule

// File: rtl/spi_seq_checker.sv
module spi_seq_checker
  import spi_seq_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_n_i,
  input logic [2:0] phase_o,
  input logic       slot_hit_o,
  input logic       addr_swap_o,
  input logic [3:0] lane_oe_o
);

  // R8
  cs_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_i |=> (phase_o == 3'(PH_IDLE)));

  // R3
  opcode_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_n_i && phase_o == 3'(PH_IDLE)) |=> (phase_o == 3'(PH_OPCODE)));

  // R6
  lane_oe_payload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lane_oe_o != 4'b0) |-> (phase_o == 3'(PH_PAYLOAD)));

  // R6
  payload_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_n_i && phase_o == 3'(PH_PAYLOAD)) |=> (phase_o == 3'(PH_PAYLOAD)));

  // R7
  ignore_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_n_i && phase_o == 3'(PH_IGNORE)) |=> (phase_o == 3'(PH_IGNORE) && !slot_hit_o));

  // R9
  swap_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_swap_o |-> (phase_o == 3'(PH_ADDR)));

  // R2
  hit_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_hit_o |-> (phase_o == 3'(PH_ADDR) || phase_o == 3'(PH_DUMMY) || phase_o == 3'(PH_PAYLOAD)));

endmodule

bind spi_cmd_sequencer spi_seq_checker i_spi_seq_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cs_n_i      (cs_n_i),
  .phase_o     (phase_o),
  .slot_hit_o  (slot_hit_o),
  .addr_swap_o (addr_swap_o),
  .lane_oe_o   (lane_oe_o)
);

// File: tb/test_spi_cmd_sequencer.sv
`timescale 1ns/1ps
module test_spi_cmd_sequencer;

  localparam int SLOTS = 16;
  localparam int DW    = 20;

  logic              clk_i = 1'b0;
  logic              rst_ni;
  logic              cs_n_i;
  logic              bit_stb_i;
  logic              opcode_valid_i;
  logic [7:0]        opcode_i;
  logic              addr_wide_i;
  logic [SLOTS*DW-1:0] desc_table_i;
  logic [2:0]        phase_o;
  logic [3:0]        slot_o;
  logic              slot_hit_o;
  logic              addr_swap_o;
  logic [3:0]        lane_oe_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk_i = ~clk_i;

  spi_cmd_sequencer i_spi_cmd_sequencer (
    .clk_i, .rst_ni, .cs_n_i, .bit_stb_i, .opcode_valid_i, .opcode_i,
    .addr_wide_i, .desc_table_i, .phase_o, .slot_o, .slot_hit_o,
    .addr_swap_o, .lane_oe_o
  );

  function automatic logic [DW-1:0] mk(input logic [7:0] op, input logic aen, input logic swp,
                                       input logic wide, input logic [2:0] dm1, input logic den,
                                       input logic [3:0] lanes, input logic dir);
    return {dir, lanes, den, dm1, wide, swp, aen, op};
  endfunction

  task automatic put(input int slot, input logic [DW-1:0] d);
    desc_table_i[slot*DW +: DW] = d;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic strobes(input int n);
    for (int i = 0; i < n; i++) begin
      bit_stb_i = 1'b1;
      tick();
    end
    bit_stb_i = 1'b0;
  endtask

  task automatic start_op(input logic [7:0] op);
    cs_n_i = 1'b0;
    tick();
    chk("R3 opcode phase", phase_o, 1);
    opcode_i = op;
    opcode_valid_i = 1'b1;
    tick();
    opcode_valid_i = 1'b0;
  endtask

  task automatic finish_txn(input string tag);
    cs_n_i = 1'b1;
    tick();
    chk({tag, " R8 idle"}, phase_o, 0);
    chk({tag, " R1 oe"}, lane_oe_o, 0);
    chk({tag, " R1 hit"}, slot_hit_o, 0);
  endtask

  task automatic t_reset();
    chk("R1 phase", phase_o, 0);
    chk("R1 hit", slot_hit_o, 0);
    chk("R1 oe", lane_oe_o, 0);
    chk("R1 swap", addr_swap_o, 0);
  endtask

  task automatic t_read_narrow();
    addr_wide_i = 1'b0;
    start_op(8'h03);
    chk("R3 addr", phase_o, 2);
    chk("R2 slot", slot_o, 2);
    chk("R2 hit", slot_hit_o, 1);
    chk("R6 oe in addr", lane_oe_o, 0);
    strobes(23);
    chk("R4 24b still addr", phase_o, 2);
    strobes(1);
    chk("R4 24b done", phase_o, 4);
    chk("R6 single lane", lane_oe_o, 4'b0010);
    strobes(9);
    chk("R6 payload holds", phase_o, 4);
    finish_txn("read");
  endtask

  task automatic t_fast_wide();
    addr_wide_i = 1'b1;
    start_op(8'h0C);
    chk("R2 slot5", slot_o, 5);
    chk("R9 swap in addr", addr_swap_o, 1);
    strobes(31);
    chk("R4 32b still addr", phase_o, 2);
    strobes(1);
    chk("R5 dummy after addr", phase_o, 3);
    chk("R9 swap off", addr_swap_o, 0);
    strobes(7);
    chk("R5 dummy 8 still", phase_o, 3);
    strobes(1);
    chk("R5 dummy 8 done", phase_o, 4);
    finish_txn("fast");
  endtask

  task automatic t_wide_unaffected();
    addr_wide_i = 1'b1;
    start_op(8'h0B);
    chk("R9 no swap", addr_swap_o, 0);
    strobes(23);
    chk("R4 not eligible still addr", phase_o, 2);
    strobes(1);
    chk("R4 not eligible 24", phase_o, 3);
    strobes(1);
    chk("R5 dummy 1", phase_o, 4);
    finish_txn("unaff");
  endtask

  task automatic t_nomatch();
    start_op(8'h77);
    chk("R7 ignore", phase_o, 5);
    chk("R7 hit low", slot_hit_o, 0);
    strobes(40);
    chk("R7 stays", phase_o, 5);
    chk("R7 oe", lane_oe_o, 0);
    finish_txn("nomatch");
  endtask

  task automatic t_duplicate();
    start_op(8'hA5);
    chk("R2 lowest slot", slot_o, 8);
    chk("R3 direct payload", phase_o, 4);
    chk("R6 quad oe", lane_oe_o, 4'b1111);
    finish_txn("dup");
  endtask

  task automatic t_write_dir();
    addr_wide_i = 1'b0;
    start_op(8'h02);
    strobes(24);
    chk("R6 write payload", phase_o, 4);
    chk("R6 dir0 no oe", lane_oe_o, 0);
    finish_txn("write");
  endtask

  task automatic t_dummy_only();
    start_op(8'h9F);
    chk("R5 dummy first", phase_o, 3);
    strobes(2);
    chk("R5 dummy 3 still", phase_o, 3);
    strobes(1);
    chk("R5 dummy 3 done", phase_o, 4);
    chk("R6 upper lanes", lane_oe_o, 4'b1100);
    finish_txn("donly");
  endtask

  task automatic t_collide();
    addr_wide_i = 1'b0;
    start_op(8'h03);
    strobes(23);
    bit_stb_i = 1'b1;
    cs_n_i = 1'b1;
    tick();
    bit_stb_i = 1'b0;
    chk("R8 cs beats last strobe", phase_o, 0);
    chk("R8 oe low", lane_oe_o, 0);
    cs_n_i = 1'b0;
    tick();
    opcode_i = 8'hA5;
    opcode_valid_i = 1'b1;
    cs_n_i = 1'b1;
    tick();
    opcode_valid_i = 1'b0;
    chk("R8 cs beats opcode", phase_o, 0);
    chk("R8 no hit", slot_hit_o, 0);
    start_op(8'hA5);
    chk("R3 restart", phase_o, 4);
    finish_txn("collide");
  endtask

  initial begin
    rst_ni = 1'b0;
    cs_n_i = 1'b1;
    bit_stb_i = 1'b0;
    opcode_valid_i = 1'b0;
    opcode_i = 8'h00;
    addr_wide_i = 1'b0;
    desc_table_i = '0;
    for (int s = 0; s < SLOTS; s++) put(s, mk(8'hF0 + 8'(s) - 8'd16 * 8'(s / 16), 0, 0, 0, 3'd7, 0, 4'b0, 0));
    put(0, mk(8'hE0, 0, 0, 0, 3'd7, 0, 4'b0, 0));
    put(2,  mk(8'h03, 1, 0, 1, 3'd7, 0, 4'b0010, 1));
    put(3,  mk(8'h02, 1, 0, 0, 3'd7, 0, 4'b0001, 0));
    put(5,  mk(8'h0C, 1, 1, 1, 3'd7, 1, 4'b0010, 1));
    put(6,  mk(8'h0B, 1, 0, 0, 3'd0, 1, 4'b0011, 1));
    put(8,  mk(8'hA5, 0, 0, 0, 3'd7, 0, 4'b1111, 1));
    put(9,  mk(8'h9F, 0, 0, 0, 3'd2, 1, 4'b1100, 1));
    put(12, mk(8'hA5, 1, 0, 0, 3'd7, 1, 4'b0001, 1));
    tick();
    tick();
    t_reset();
    rst_ni = 1'b1;
    tick();
    t_reset();
    t_read_narrow();
    t_fast_wide();
    t_wide_unaffected();
    t_nomatch();
    t_duplicate();
    t_write_dir();
    t_dummy_only();
    t_collide();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule